// File: doc/BRIEF.md
# Block Lock Protection Controller

This block decides which parts of a flash array may be changed. Each block of the array has a lock bit, and one further bit locks the whole device for good. Software sets a lock with two command writes: a setup write and then a confirm write. The confirm either names a block or selects the device-wide permanent lock. Once the sequence is accepted, a timed set-lock operation runs with busy raised, and the bit is written when it ends.

Every word-program or block-erase request that reaches the block is answered, one cycle later, with either a grant or a deny. The answer depends on three things: the target block's lock bit, the level of the protect pin (normal or high-voltage), and the permanent lock bit. The block also keeps two sticky error flags, one for protection violations and one for malformed command sequences. A clear-status command resets both flags. Clearing lock bits and the array itself are handled elsewhere.

Addresses are `IDX_W + OFFSET_W` bits wide. The block index is the top `IDX_W` bits. `NUM_BLOCKS` must be a power of two.

Top module: `lockprot_ctrl`

## Requirements
- R1: A setup write (code 0x60) followed by a block confirm (code 0x01) whose address lies in the same block as the setup address sets that block's lock bit. The block index is the address bits above the low `OFFSET_W` bits. The bit is written when busy falls.
- R2: A setup write followed by a permanent confirm (code 0xF1) with any address, while `pin_hv` is 1 and the permanent bit is clear, sets `perm_locked` when busy falls.
- R3: A permanent confirm while `pin_hv` is 0, or while `perm_locked` is already 1, changes nothing, starts no operation and sets `prot_err`.
- R4: While `perm_locked` is 1, a block confirm changes no lock bit, starts no operation and sets `prot_err`.
- R5: After a setup write, any command other than a block confirm naming the same block or a permanent confirm aborts the sequence. The abort sets `seq_err`, returns the controller to idle and starts no operation.
- R6: After an accepted confirm, `busy` is high for exactly `LOCK_CYCLES` cycles, starting in the cycle after the confirm. Commands written while busy is high are ignored.
- R7: A request on `op_req` is answered in the next cycle by exactly one of `op_grant` or `op_deny`. It is granted when the target block is unlocked, or when the block is locked but `pin_hv` is 1 and `perm_locked` is 0. It is denied otherwise. With no request, both outputs stay low.
- R8: A denied request sets `prot_err` in the same cycle that `op_deny` rises.
- R9: A clear-status write (code 0x50) while idle clears `prot_err` and `seq_err`. If a new error arrives in the same cycle, that error's flag is set rather than cleared.
- R10: After reset, all lock bits, `perm_locked`, `busy`, both error flags, `op_grant` and `op_deny` are 0.
- R11: Lock bits and `perm_locked` never return to 0 except through reset.
- R12: A request in the same cycle that a lock bit is written is judged against the lock state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_hv | input | 1 | Protect pin level: 1 = high-voltage, 0 = normal |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_addr | input | IDX_W+OFFSET_W | Address carried with the command |
| op_req | input | 1 | Program or erase request |
| op_addr | input | IDX_W+OFFSET_W | Target address of the request |
| lock_bits | output | NUM_BLOCKS | Per-block lock bits |
| perm_locked | output | 1 | Permanent lock bit |
| busy | output | 1 | Set-lock operation in progress |
| prot_err | output | 1 | Sticky protection-violation flag |
| seq_err | output | 1 | Sticky command-sequence error flag |
| op_grant | output | 1 | Request permitted (one cycle after request) |
| op_deny | output | 1 | Request refused (one cycle after request) |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the end of a set-lock operation and a permission decision on the same block. The bench holds a request to the block being locked so that it meets the final busy cycle. It then expects a grant, because the decision uses the pre-write state, while the lock bit appears at the same edge. A second request afterwards must be denied.

The second pair is a clear-status write and a denied request in the same cycle. The bench expects `prot_err` to stay set, since the new error wins. In the same cycle, the previously set `seq_err` must be cleared.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURN  = 2'd2
    } seq_state_t;

    localparam logic [7:0] CMD_LOCK_SETUP    = 8'h60;
    localparam logic [7:0] CMD_CONFIRM_BLOCK = 8'h01;
    localparam logic [7:0] CMD_CONFIRM_PERM  = 8'hF1;
    localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;

endpackage

// File: rtl/lockprot_seq.sv
module lockprot_seq
    import lockprot_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int LOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic             pin_hv,
    input  logic             perm_locked,
    output logic             busy,
    output logic             commit_blk,
    output logic             commit_perm,
    output logic [IDX_W-1:0] commit_idx,
    output logic             prot_err_set,
    output logic             seq_err_set,
    output logic             status_clr
);
    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    seq_state_t       state, state_n;
    logic [IDX_W-1:0] tgt_idx, tgt_idx_n;
    logic             tgt_perm, tgt_perm_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tgt_idx  <= '0;
            tgt_perm <= 1'b0;
            cnt      <= '0;
        end else begin
            state    <= state_n;
            tgt_idx  <= tgt_idx_n;
            tgt_perm <= tgt_perm_n;
            cnt      <= cnt_n;
        end
    end

    // Transitions and event outputs
    always_comb begin
        state_n      = state;
        tgt_idx_n    = tgt_idx;
        tgt_perm_n   = tgt_perm;
        cnt_n        = cnt;
        commit_blk   = 1'b0;
        commit_perm  = 1'b0;
        prot_err_set = 1'b0;
        seq_err_set  = 1'b0;
        status_clr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_code == CMD_LOCK_SETUP) begin
                        state_n   = ST_ARMED;
                        tgt_idx_n = cmd_blk;
                    end else if (cmd_code == CMD_CLEAR_STATUS) begin
                        status_clr = 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (cmd_valid) begin
                    state_n = ST_IDLE;
                    if (cmd_code == CMD_CONFIRM_BLOCK && cmd_blk == tgt_idx) begin
                        if (perm_locked) begin
                            prot_err_set = 1'b1;
                        end else begin
                            state_n    = ST_BURN;
                            tgt_perm_n = 1'b0;
                            cnt_n      = CNT_LAST;
                        end
                    end else if (cmd_code == CMD_CONFIRM_PERM) begin
                        if (perm_locked || !pin_hv) begin
                            prot_err_set = 1'b1;
                        end else begin
                            state_n    = ST_BURN;
                            tgt_perm_n = 1'b1;
                            cnt_n      = CNT_LAST;
                        end
                    end else begin
                        seq_err_set = 1'b1;
                    end
                end
            end
            ST_BURN: begin
                if (cnt == '0) begin
                    state_n     = ST_IDLE;
                    commit_blk  = !tgt_perm;
                    commit_perm = tgt_perm;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign busy       = (state == ST_BURN);
    assign commit_idx = tgt_idx;

endmodule

// File: rtl/lockprot_store.sv
module lockprot_store #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_blk,
    input  logic                  commit_perm,
    input  logic [IDX_W-1:0]      commit_idx,
    input  logic                  seq_prot_set,
    input  logic                  gate_prot_set,
    input  logic                  seq_err_set,
    input  logic                  status_clr,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  perm_locked,
    output logic                  prot_err,
    output logic                  seq_err
);
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lock_bits[g] <= 1'b0;
            else if (commit_blk && !perm_locked && commit_idx == IDX_W'(g))
                lock_bits[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_locked <= 1'b0;
            prot_err    <= 1'b0;
            seq_err     <= 1'b0;
        end else begin
            if (commit_perm)
                perm_locked <= 1'b1;
            if (seq_prot_set || gate_prot_set)
                prot_err <= 1'b1;
            else if (status_clr)
                prot_err <= 1'b0;
            if (seq_err_set)
                seq_err <= 1'b1;
            else if (status_clr)
                seq_err <= 1'b0;
        end
    end

endmodule

// File: rtl/lockprot_gate.sv
module lockprot_gate #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_req,
    input  logic [IDX_W-1:0]      op_blk,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  perm_locked,
    input  logic                  pin_hv,
    output logic                  deny_evt,
    output logic                  op_grant,
    output logic                  op_deny
);
    logic blk_locked;
    logic allow;

    assign blk_locked = lock_bits[op_blk];
    assign allow      = !blk_locked || (pin_hv && !perm_locked);
    assign deny_evt   = op_req && !allow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_grant <= 1'b0;
            op_deny  <= 1'b0;
        end else begin
            op_grant <= op_req && allow;
            op_deny  <= deny_evt;
        end
    end

endmodule

// File: rtl/lockprot_ctrl.sv
module lockprot_ctrl #(
    parameter int NUM_BLOCKS  = 8,
    parameter int OFFSET_W    = 4,
    parameter int LOCK_CYCLES = 4,
    parameter int IDX_W       = $clog2(NUM_BLOCKS),
    parameter int ADDR_W      = IDX_W + OFFSET_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_hv,
    input  logic                  cmd_valid,
    input  logic [7:0]            cmd_code,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic                  op_req,
    input  logic [ADDR_W-1:0]     op_addr,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  perm_locked,
    output logic                  busy,
    output logic                  prot_err,
    output logic                  seq_err,
    output logic                  op_grant,
    output logic                  op_deny
);
    logic [IDX_W-1:0] cmd_blk, op_blk, commit_idx;
    logic commit_blk, commit_perm, seq_prot_set, seq_err_set, status_clr, deny_evt;

    assign cmd_blk = IDX_W'(cmd_addr >> OFFSET_W);
    assign op_blk  = IDX_W'(op_addr >> OFFSET_W);

    lockprot_seq #(.IDX_W(IDX_W), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_blk(cmd_blk), .pin_hv(pin_hv), .perm_locked(perm_locked),
        .busy(busy), .commit_blk(commit_blk), .commit_perm(commit_perm),
        .commit_idx(commit_idx), .prot_err_set(seq_prot_set),
        .seq_err_set(seq_err_set), .status_clr(status_clr)
    );

    lockprot_store #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_blk(commit_blk), .commit_perm(commit_perm),
        .commit_idx(commit_idx), .seq_prot_set(seq_prot_set), .gate_prot_set(deny_evt),
        .seq_err_set(seq_err_set), .status_clr(status_clr), .lock_bits(lock_bits),
        .perm_locked(perm_locked), .prot_err(prot_err), .seq_err(seq_err)
    );

    lockprot_gate #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_blk(op_blk),
        .lock_bits(lock_bits), .perm_locked(perm_locked), .pin_hv(pin_hv),
        .deny_evt(deny_evt), .op_grant(op_grant), .op_deny(op_deny)
    );

endmodule

// File: rtl/lockprot_ctrl_chk.sv
module lockprot_ctrl_chk #(
    parameter int NUM_BLOCKS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_req,
    input logic [NUM_BLOCKS-1:0] lock_bits,
    input logic                  perm_locked,
    input logic                  busy,
    input logic                  prot_err,
    input logic                  op_grant,
    input logic                  op_deny
);
    AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_bits & $past(lock_bits)) == $past(lock_bits))); // R11

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(perm_locked)); // R11

    AST_PERM_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(perm_locked) |-> (lock_bits == $past(lock_bits))); // R4

    AST_WRITE_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_bits != $past(lock_bits)) || $rose(perm_locked)) |-> $fell(busy)); // R6

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> (op_grant != op_deny)); // R7

    AST_NO_IDLE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !op_req |=> (!op_grant && !op_deny)); // R7

    AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_deny |-> prot_err); // R8

endmodule

bind lockprot_ctrl lockprot_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .lock_bits(lock_bits),
    .perm_locked(perm_locked), .busy(busy), .prot_err(prot_err),
    .op_grant(op_grant), .op_deny(op_deny)
);

// File: tb/lockprot_ctrl_test.sv
`timescale 1ns/1ps
module lockprot_ctrl_test;
    localparam int NB = 8;
    localparam int OW = 4;
    localparam int LC = 4;
    localparam int AW = 3 + OW;
    localparam logic [7:0] C_SETUP = 8'h60, C_CBLK = 8'h01, C_CPERM = 8'hF1, C_CLR = 8'h50;

    logic clk = 1'b0, rst_n = 1'b0, pin_hv = 1'b0, cmd_valid = 1'b0, op_req = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [AW-1:0] cmd_addr = '0, op_addr = '0;
    logic [NB-1:0] lock_bits;
    logic perm_locked, busy, prot_err, seq_err, op_grant, op_deny;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lockprot_ctrl #(.NUM_BLOCKS(NB), .OFFSET_W(OW), .LOCK_CYCLES(LC)) uut (
        .clk(clk), .rst_n(rst_n), .pin_hv(pin_hv), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .op_req(op_req), .op_addr(op_addr),
        .lock_bits(lock_bits), .perm_locked(perm_locked), .busy(busy),
        .prot_err(prot_err), .seq_err(seq_err), .op_grant(op_grant), .op_deny(op_deny)
    );

    // {pin_hv, block[2:0], expected grant} with blocks 2 and 5 locked, permanent clear
    localparam logic [4:0] OPS [7] = '{
        5'b0_000_1, 5'b0_010_0, 5'b1_010_1, 5'b0_101_0,
        5'b1_101_1, 5'b0_111_1, 5'b1_011_1
    };

    function automatic logic [AW-1:0] mk(input int blk, input int off);
        return {3'(blk), 4'(off)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] code, input int blk, input int off);
        cmd_valid = 1'b1; cmd_code = code; cmd_addr = mk(blk, off);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_op(input int blk, input logic hv);
        op_req = 1'b1; op_addr = mk(blk, 3); pin_hv = hv;
        @(negedge clk);
        op_req = 1'b0; pin_hv = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 locks", 32'(lock_bits), 0);
        check("R10 perm", 32'(perm_locked), 0);
        check("R10 busy", 32'(busy), 0);
        check("R10 errs", {30'd0, prot_err, seq_err}, 0);
        check("R10 answers", {30'd0, op_grant, op_deny}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 lock block 2, with a setup written during busy (R6 ignore)
        send_cmd(C_SETUP, 2, 0);
        send_cmd(C_CBLK, 2, 7);
        check("R6 busy after confirm", 32'(busy), 1);
        send_cmd(C_SETUP, 6, 0);
        wait_busy(n);
        check("R1 block 2 locked", 32'(lock_bits), 32'h04);
        send_cmd(C_CBLK, 6, 0);
        @(negedge clk);
        check("R6 command during busy ignored", 32'(lock_bits[6]), 0);
        check("R6 no busy from stray confirm", 32'(busy), 0);

        // R1 / R6 lock block 5 with busy length count
        send_cmd(C_SETUP, 5, 1);
        send_cmd(C_CBLK, 5, 14);
        wait_busy(n);
        check("R6 busy length", n, LC);
        check("R1 block 5 locked", 32'(lock_bits), 32'h24);

        // R7 table walk
        for (int i = 0; i < 7; i++) begin
            do_op(int'(OPS[i][3:1]), OPS[i][4]);
            check($sformatf("R7 grant vec %0d", i), 32'(op_grant), 32'(OPS[i][0]));
            check($sformatf("R7 deny vec %0d", i), 32'(op_deny), 32'(!OPS[i][0]));
        end
        check("R8 deny sets prot_err", 32'(prot_err), 1);
        @(negedge clk);
        check("R7 no answer without request", {30'd0, op_grant, op_deny}, 0);
        send_cmd(C_CLR, 0, 0);
        check("R9 clear prot_err", 32'(prot_err), 0);

        // R5 aborted sequences
        send_cmd(C_SETUP, 1, 0);
        send_cmd(C_CBLK, 4, 0);
        check("R5 mismatched block seq_err", 32'(seq_err), 1);
        check("R5 no busy", 32'(busy), 0);
        repeat (LC + 1) @(negedge clk);
        check("R5 no lock written", 32'(lock_bits), 32'h24);
        send_cmd(C_CLR, 0, 0);
        check("R9 clear seq_err", 32'(seq_err), 0);
        send_cmd(C_SETUP, 1, 0);
        send_cmd(8'h40, 1, 0);
        check("R5 foreign code seq_err", 32'(seq_err), 1);

        // R9 clear and deny in the same cycle
        cmd_valid = 1'b1; cmd_code = C_CLR; cmd_addr = '0;
        op_req = 1'b1; op_addr = mk(2, 0);
        @(negedge clk);
        cmd_valid = 1'b0; op_req = 1'b0;
        check("R9 new deny wins over clear", 32'(prot_err), 1);
        check("R9 seq_err cleared", 32'(seq_err), 0);
        send_cmd(C_CLR, 0, 0);
        check("R9 prot_err cleared", 32'(prot_err), 0);

        // R12 request meeting the lock write
        send_cmd(C_SETUP, 3, 0);
        send_cmd(C_CBLK, 3, 2);
        repeat (LC - 1) @(negedge clk);
        check("R6 last busy cycle", 32'(busy), 1);
        do_op(3, 1'b0);
        check("R12 judged on old state", 32'(op_grant), 1);
        check("R12 lock written same edge", 32'(lock_bits[3]), 1);
        do_op(3, 1'b0);
        check("R12 later request denied", 32'(op_deny), 1);
        send_cmd(C_CLR, 0, 0);

        // R3 permanent confirm at normal pin level
        send_cmd(C_SETUP, 0, 0);
        send_cmd(C_CPERM, 6, 5);
        check("R3 no busy", 32'(busy), 0);
        check("R3 prot_err", 32'(prot_err), 1);
        check("R3 perm clear", 32'(perm_locked), 0);
        send_cmd(C_CLR, 0, 0);

        // R2 permanent lock with high-voltage pin
        pin_hv = 1'b1;
        send_cmd(C_SETUP, 0, 0);
        send_cmd(C_CPERM, 7, 9);
        wait_busy(n);
        pin_hv = 1'b0;
        check("R2 busy length", n, LC);
        check("R2 perm set", 32'(perm_locked), 1);

        // R7 override lost once permanent
        do_op(2, 1'b1);
        check("R7 perm disables override", 32'(op_deny), 1);
        do_op(0, 1'b1);
        check("R7 unlocked still granted", 32'(op_grant), 1);
        send_cmd(C_CLR, 0, 0);

        // R4 block lock refused after permanent
        send_cmd(C_SETUP, 0, 0);
        send_cmd(C_CBLK, 0, 1);
        check("R4 no busy", 32'(busy), 0);
        check("R4 prot_err", 32'(prot_err), 1);
        repeat (LC + 1) @(negedge clk);
        check("R4 block 0 unchanged", 32'(lock_bits[0]), 0);
        send_cmd(C_CLR, 0, 0);

        // R3 permanent already set
        pin_hv = 1'b1;
        send_cmd(C_SETUP, 0, 0);
        send_cmd(C_CPERM, 0, 0);
        pin_hv = 1'b0;
        check("R3 repeat perm refused", 32'(prot_err), 1);
        check("R3 repeat no busy", 32'(busy), 0);

        // R11 final state held
        repeat (3) @(negedge clk);
        check("R11 locks held", 32'(lock_bits), 32'h2C);
        check("R11 perm held", 32'(perm_locked), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule